// File: doc/BRIEF.md
# Reconfigurable Bit-Plane Correlation Array

This block compares a stream of input samples against a fixed pattern of one reference bit per tap. It produces a new match count on every clock. The array has eight stages of 32 single-bit taps. A three-bit configuration decides how the stages are chained. Narrow samples form one long chain, and wider samples form several shorter chains, one for each bit-plane of the sample. A dual setting splits the array into two independent halves, for two-dimensional windows of up to four rows.

A tap adds one to the score when its stored data bit equals its reference bit and its mask bit is clear. The block also reports a count for each stage, so that logic downstream can weight the bit-planes. For cascading, it exposes the oldest data tap of every stage and the matching reference bit.

Configuration field `cfg` is decoded as follows:
- `cfg[1:0]` selects the sample width: 0 = 1 bit, 1 = 2 bits, 2 = 4 bits, 3 = 8 bits.
- `cfg[2]` selects the dual setting.

Top module: `bitplane_corr`

## Requirements
- R1: While `rst_n` is low, every tap is cleared, and `score_a`, `score_b`, `stage_score` and `data_out` read zero.
- R2: With `cfg` = 000 (1-bit, single), `din[0]` enters tap 0 of stage 0 on each rising edge. Tap j of stage s is flat index 32*s+j, and stage s tap 0 takes stage s-1 tap 31, forming one 256-tap chain. `score_a` counts unmasked taps whose data bit equals the reference bit at the same flat index.
- R3: The score registered on a rising edge covers the taps as they stood before that edge. A sample presented at edge k therefore first counts in the score visible after edge k+1.
- R4: In single mode with sample width W (2, 4 or 8), each plane holds 8/W stages. Stage s starts a plane when s is a multiple of 8/W, and then takes `din[s/(8/W)]`; otherwise it continues from stage s-1.
- R5: With `cfg[2]`=1 and width W of 1, 2 or 4, stages 0-3 form correlator A fed from `din[W-1:0]`, and stages 4-7 form correlator B fed from `din[4+W-1:4]`. Each half uses the R4 chaining within its own four stages. `score_a` counts stages 0-3 and `score_b` counts stages 4-7.
- R6: A tap whose `mask_bits` bit is 1 never contributes to any score. With every mask bit set, all scores are zero.
- R7: `cfg` = 111 (dual with 8-bit samples) behaves exactly like `cfg` = 000.
- R8: Data lines not used by the selected setting have no effect on any output.
- R9: `stage_score` field s (bits 6*s+5 : 6*s) holds the unmasked match count of stage s, registered with the same timing as the scores. In single mode `score_a` equals the sum of all eight fields.
- R10: `data_out[s]` is the current content of tap 31 of stage s, and `ref_out[s]` is reference bit 32*s+31.
- R11: Outside the dual setting, `score_b` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg | input | 3 | Width select [1:0], dual select [2] |
| din | input | 8 | Sample input, bit 0 is the LSB |
| ref_bits | input | 256 | Reference bit per tap |
| mask_bits | input | 256 | 1 removes the tap from scoring |
| score_a | output | 9 | Score of the single correlator, or of half A |
| score_b | output | 9 | Score of half B in dual setting, else zero |
| stage_score | output | 48 | Per-stage match counts, 6 bits each |
| data_out | output | 8 | Oldest data tap of each stage |
| ref_out | output | 8 | Reference bit of each stage's oldest tap |

## Verification
The configuration can change at the same edge that scores the taps. The new setting then re-routes the stage feeds, and the score is grouped under the new split while the taps were laid down under the old routing. The stimulus table changes `cfg` from one step to the next, mixing widths and the dual setting while data keeps flowing. An independent tap model in the bench predicts both effects on every step: the score from the pre-edge taps with the current setting, and the next tap contents. Directed steps then pin the latency, full masking, the fallback setting and the split of the halves with literal values.

// File: rtl/bitplane_corr.sv
module bitplane_corr #(
  parameter int STAGES = 8,
  parameter int TAPS   = 32
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [2:0]                             cfg,
  input  logic [STAGES-1:0]                      din,
  input  logic [STAGES*TAPS-1:0]                 ref_bits,
  input  logic [STAGES*TAPS-1:0]                 mask_bits,
  output logic [$clog2(STAGES*TAPS+1)-1:0]       score_a,
  output logic [$clog2(STAGES*TAPS+1)-1:0]       score_b,
  output logic [STAGES*$clog2(TAPS+1)-1:0]       stage_score,
  output logic [STAGES-1:0]                      data_out,
  output logic [STAGES-1:0]                      ref_out
);
  localparam int N    = STAGES * TAPS;
  localparam int SW   = $clog2(TAPS + 1);
  localparam int TW   = $clog2(N + 1);
  localparam int HALF = STAGES / 2;
  localparam int LW   = $clog2(STAGES);

  logic       odd_cfg, dual;
  logic [1:0] wsel;
  assign odd_cfg = cfg[2] & (&cfg[1:0]);
  assign dual    = cfg[2] & ~odd_cfg;
  assign wsel    = odd_cfg ? 2'd0 : cfg[1:0];

  wire  [N-1:0]         tap_q;
  wire  [N-1:0]         hit;
  wire  [STAGES*SW-1:0] cnt;
  logic [STAGES-1:0]    feed;

  assign hit = ~(tap_q ^ ref_bits) & ~mask_bits;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    localparam int LOC_D  = s % HALF;
    localparam int BASE_D = (s / HALF) * HALF;
    int            loc, sh, ln;
    logic          head;
    logic [TAPS-1:0] sr;

    always_comb begin
      loc  = dual ? LOC_D : s;
      sh   = dual ? (LW - 1 - int'(wsel)) : (LW - int'(wsel));
      ln   = (dual ? BASE_D : 0) + (loc >> sh);
      head = ((loc >> sh) << sh) == loc;
    end

    if (s == 0) begin : g_first
      assign feed[s] = din[LW'(ln)];
    end else begin : g_rest
      assign feed[s] = head ? din[LW'(ln)] : tap_q[s*TAPS-1];
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sr <= '0;
      else        sr <= {sr[TAPS-2:0], feed[s]};

    assign tap_q[s*TAPS +: TAPS] = sr;
    assign cnt[s*SW +: SW]       = SW'($countones(hit[s*TAPS +: TAPS]));
    assign data_out[s]           = sr[TAPS-1];
    assign ref_out[s]            = ref_bits[s*TAPS+TAPS-1];
  end

  logic [TW-1:0] sum_a, sum_b;
  always_comb begin
    sum_a = '0;
    sum_b = '0;
    for (int s = 0; s < STAGES; s++) begin
      if (dual && s >= HALF) sum_b = sum_b + TW'(cnt[s*SW +: SW]);
      else                   sum_a = sum_a + TW'(cnt[s*SW +: SW]);
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      score_a     <= '0;
      score_b     <= '0;
      stage_score <= '0;
    end else begin
      score_a     <= sum_a;
      score_b     <= sum_b;
      stage_score <= cnt;
    end
endmodule

// File: rtl/bitplane_corr_chk.sv
module bitplane_corr_chk #(
  parameter int STAGES = 8,
  parameter int TAPS   = 32
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic [2:0]                         cfg,
  input logic [STAGES-1:0]                  din,
  input logic [STAGES*TAPS-1:0]             mask_bits,
  input logic [STAGES*TAPS-1:0]             tap_q,
  input logic [$clog2(STAGES*TAPS+1)-1:0]   score_a,
  input logic [$clog2(STAGES*TAPS+1)-1:0]   score_b,
  input logic [STAGES*$clog2(TAPS+1)-1:0]   stage_score
);
  localparam int SW   = $clog2(TAPS + 1);
  localparam int TW   = $clog2(STAGES*TAPS + 1);
  localparam int HALF = STAGES / 2;

  function automatic logic [TW-1:0] total(input logic [STAGES*SW-1:0] v);
    logic [TW-1:0] t = '0;
    for (int s = 0; s < STAGES; s++) t = t + TW'(v[s*SW +: SW]);
    return t;
  endfunction

  logic single_mode;
  assign single_mode = !cfg[2] || (&cfg[1:0]);

  // R11
  b_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    single_mode |=> score_b == '0);

  // R6
  mask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_bits) |=> (score_a == '0 && score_b == '0));

  // R9
  stage_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    single_mode |=> score_a == total(stage_score));

  // R2
  chain_1bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg == 3'b000) |=> (tap_q[0] == $past(din[0]) && tap_q[TAPS] == $past(tap_q[TAPS-1])));

  // R4
  plane_8bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg == 3'b011) |=> tap_q[TAPS] == $past(din[1]));

  // R5
  dual_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg == 3'b100) |=> tap_q[HALF*TAPS] == $past(din[HALF]));

  // R7
  fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg == 3'b111) |=> (tap_q[0] == $past(din[0]) && tap_q[TAPS] == $past(tap_q[TAPS-1])));
endmodule

bind bitplane_corr bitplane_corr_chk #(.STAGES(STAGES), .TAPS(TAPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg(cfg), .din(din), .mask_bits(mask_bits),
  .tap_q(tap_q), .score_a(score_a), .score_b(score_b), .stage_score(stage_score)
);

// File: tb/bitplane_corr_test.sv
module bitplane_corr_test;
  localparam int TAPS = 32;
  localparam int N    = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    cfg = 3'd0;
  logic [7:0]    din = 8'd0;
  logic [N-1:0]  ref_v = '0;
  logic [N-1:0]  mask_v = '0;
  wire  [8:0]    score_a, score_b;
  wire  [47:0]   stage_score;
  wire  [7:0]    data_out, ref_out;

  bitplane_corr uut (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .din(din), .ref_bits(ref_v), .mask_bits(mask_v),
    .score_a(score_a), .score_b(score_b), .stage_score(stage_score),
    .data_out(data_out), .ref_out(ref_out)
  );

  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [N-1:0] mt = '0;
  logic [7:0]   lf = 8'h5D;

  localparam logic [10:0] VEC [16] = '{
    {3'b000, 8'h01}, {3'b000, 8'hFE}, {3'b001, 8'h03}, {3'b010, 8'h0A},
    {3'b011, 8'hC5}, {3'b100, 8'h11}, {3'b101, 8'h32}, {3'b110, 8'h97},
    {3'b111, 8'h7F}, {3'b011, 8'h3C}, {3'b000, 8'h00}, {3'b100, 8'hEE},
    {3'b010, 8'hF0}, {3'b001, 8'h5A}, {3'b110, 8'h08}, {3'b111, 8'h80}
  };

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] c);
    if (c == 3'b111) return "R7";
    if (c[2])        return "R5";
    if (c[1:0] == 0) return "R2";
    return "R4";
  endfunction

  task automatic step(input logic [7:0] d, input logic [2:0] c);
    int w, grp, spp, loc, base, n;
    bit du;
    logic [N-1:0] nx;
    logic [47:0] est;
    logic [8:0] ea, eb;
    @(negedge clk);
    din = d;
    cfg = c;
    @(posedge clk);
    #1;
    if (c == 3'b111) begin w = 1; du = 0; end
    else begin w = 1 << c[1:0]; du = c[2]; end
    ea = '0; eb = '0; est = '0;
    for (int s = 0; s < 8; s++) begin
      n = 0;
      for (int j = 0; j < TAPS; j++)
        if (!mask_v[s*TAPS+j] && mt[s*TAPS+j] == ref_v[s*TAPS+j]) n++;
      est[s*6 +: 6] = 6'(n);
      if (du && s >= 4) eb = eb + 9'(n); else ea = ea + 9'(n);
    end
    check(tag_of(c), "score_a", score_a, ea);
    check(du ? "R5" : "R11", "score_b", score_b, eb);
    check("R9", "stage_score", stage_score, est);
    grp = du ? 4 : 8;
    spp = grp / w;
    for (int s = 0; s < 8; s++) begin
      loc  = du ? s % 4 : s;
      base = (du && s >= 4) ? 4 : 0;
      for (int j = TAPS - 1; j > 0; j--) nx[s*TAPS+j] = mt[s*TAPS+j-1];
      if (loc % spp == 0) nx[s*TAPS] = d[base + loc / spp];
      else                nx[s*TAPS] = mt[s*TAPS-1];
    end
    mt = nx;
    for (int s = 0; s < 8; s++) begin
      check("R10", "data_out", data_out[s], mt[s*TAPS+TAPS-1]);
      check("R10", "ref_out", ref_out[s], ref_v[s*TAPS+TAPS-1]);
    end
  endtask

  task automatic flush(input logic [2:0] c);
    for (int i = 0; i < 260; i++) step(8'h00, c);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #20;
    // R1 reset state
    check("R1", "score_a", score_a, 0);
    check("R1", "score_b", score_b, 0);
    check("R1", "stage_score", stage_score, 0);
    check("R1", "data_out", data_out, 0);
    @(negedge clk);
    rst_n = 1'b1;

    ref_v  = {8{32'hA5C3_0F96}};
    mask_v = {8{32'h0000_F00F}};
    for (int p = 0; p < 24; p++) begin
      if (p == 12) begin
        mask_v = '0;
        ref_v  = {8{32'h3C69_E10B}};
      end
      for (int i = 0; i < 16; i++) begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        step(VEC[i][7:0] ^ lf, VEC[i][10:8]);
      end
    end

    ref_v  = '1;
    mask_v = '0;
    // R3 latency
    flush(3'b000);
    step(8'h01, 3'b000);
    check("R3", "score_a first edge", score_a, 0);
    step(8'h00, 3'b000);
    check("R3", "score_a second edge", score_a, 1);

    // R6 full mask
    mask_v = '1;
    step(8'hFF, 3'b000);
    step(8'hFF, 3'b000);
    check("R6", "score_a masked", score_a, 0);
    mask_v = '0;

    // R7 and R8: fallback ignores upper lines
    flush(3'b111);
    step(8'hFE, 3'b111);
    step(8'hFE, 3'b111);
    check("R7", "score_a fallback", score_a, 0);
    check("R8", "score_b fallback", score_b, 0);

    // R5 halves independent
    flush(3'b100);
    step(8'h10, 3'b100);
    step(8'h00, 3'b100);
    check("R5", "score_a dual", score_a, 0);
    check("R5", "score_b dual", score_b, 1);

    finish_run();
  end

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule